// File: doc/BRIEF.md
# DS2 Bit-Stuffing Multiplexer

This block merges four independent DS1-rate serial tributaries into a single DS2 bit stream. Each tributary arrives with its own clock and is written, one bit per rising edge, into a small elastic FIFO owned by that tributary. On the DS2 side a slot sequencer walks a fixed 1176-bit frame. It reads payload bits from the four FIFOs in strict rotation and fills the overhead positions with alignment bits, an externally supplied X bit and stuff-control indications.

Each frame has exactly one stuff opportunity per tributary. At the start of subframe s, the block compares the fill level of tributary s against half the FIFO depth. A FIFO that is below half full receives a dummy bit in its opportunity slot, and that slot consumes no data. A FIFO at half full or above delivers a real data bit there. The decision is announced three times ahead of the opportunity, in that subframe's C bits. This rate adaptation lets tributaries that run slightly slow or fast relative to the DS2 clock pass through without loss.

The DS2 output stays quiet after reset until every FIFO has filled to half depth. The first frame then begins, marked by a one-cycle frame-start strobe. Under- and overflow of any FIFO are latched on per-tributary sticky flags.

Top module: `ds2_stuff_mux`

## Requirements
- R1: `ds2_frame_start` is high for exactly one DS2 clock cycle, together with the first bit of each frame, and frames repeat every 1176 cycles.
- R2: A frame is 4 subframes of 294 bits. Each subframe is 6 blocks of 49 bits: one overhead bit, then 48 payload bits. Payload bit k of a block (k = 0..47) belongs to tributary k mod 4.
- R3: Overhead bits: block 0 of subframes 0, 1 and 2 carries 0, 1 and 1. Block 2 carries 0. Block 5 carries 1.
- R4: The block 0 overhead bit of subframe 3 carries the `x_bit` input.
- R5: The overhead bits of blocks 1, 3 and 4 in subframe s are identical and equal the stuff decision for tributary s: 1 means stuff, 0 means no stuff.
- R6: The stuff opportunity for tributary s is payload bit k = s of block 5 in subframe s. When stuffing, that slot carries 0 and no FIFO bit is consumed. Otherwise it carries the tributary's next data bit.
- R7: The decision for tributary s is taken on the first bit of subframe s. It is stuff when that FIFO's fill is below half its depth, and no stuff otherwise.
- R8: Every bit captured on a rising edge of `trib_clk[i]` appears exactly once, in capture order, in tributary i's data positions, across any number of FIFO pointer wraps.
- R9: After reset, `ds2_data` and `ds2_frame_start` stay 0 until every FIFO holds at least half its depth. The first frame starts after that.
- R10: A read from an empty FIFO sends 0 and sets that tributary's `fifo_udf` bit, which stays set until reset.
- R11: A write into a full FIFO is dropped and sets that tributary's `fifo_ovf` bit, which stays set until reset.
- R12: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DS2 clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| trib_clk | input | 4 | Per-tributary capture clocks |
| trib_data | input | 4 | Per-tributary serial data, sampled on rising edges of trib_clk |
| x_bit | input | 1 | Value placed in the X overhead position |
| ds2_data | output | 1 | Serial DS2 stream |
| ds2_frame_start | output | 1 | One-cycle strobe on the first bit of each frame |
| fifo_udf | output | 4 | Sticky underflow flag per tributary |
| fifo_ovf | output | 4 | Sticky overflow flag per tributary |

## Verification
The four tributaries run at slightly different rates. The bench therefore sees one channel that mostly stuffs, one that almost never stuffs, and one that alternates. A stream that drops or repeats a bit at an opportunity slot, or that reads the wrong channel in the interleave, desynchronises the per-channel scoreboard within a frame. The bench then stops one tributary clock and races another. Inverting the fill comparison or sampling the wrong channel's fill shows up as C bits of the wrong value. A flag that clears itself or never sets fails the sticky-flag checks. Overhead values, X-bit placement and the quiet start-up interval are compared position by position.

// File: rtl/ds2_mux_pkg.sv
`timescale 1ns/1ps
package ds2_mux_pkg;
    localparam int NUM_TRIB        = 4;
    localparam int NUM_SUB         = 4;
    localparam int BLK_PER_SUB     = 6;
    localparam int PAYLOAD_PER_BLK = 48;
    localparam int BLK_LEN         = PAYLOAD_PER_BLK + 1;
    localparam int SUB_LEN         = BLK_LEN * BLK_PER_SUB;
    localparam int FRAME_LEN       = SUB_LEN * NUM_SUB;
    localparam int TRIB_W          = $clog2(NUM_TRIB);
    localparam int SUB_W           = $clog2(NUM_SUB);
    localparam int BLK_W           = $clog2(BLK_PER_SUB);
    localparam int BIT_W           = $clog2(BLK_LEN);
    localparam int STUFF_BLK       = BLK_PER_SUB - 1;

    typedef enum logic [2:0] {
        SLOT_MBIT,
        SLOT_FZERO,
        SLOT_FONE,
        SLOT_CBIT,
        SLOT_DATA,
        SLOT_STUFF
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e          kind;
        logic [TRIB_W-1:0]   trib;
        logic [SUB_W-1:0]    sub;
        logic                frame_first;
        logic                sub_first;
    } slot_t;
endpackage

// File: rtl/ds2_trib_fifo.sv
`timescale 1ns/1ps
module ds2_trib_fifo #(
    parameter int DEPTH = 16
) (
    input  logic                       rst_n,
    input  logic                       wr_clk,
    input  logic                       wr_bit,
    output logic                       ovf_o,
    input  logic                       rd_clk,
    input  logic                       rd_en,
    output logic                       rd_bit,
    output logic [$clog2(DEPTH):0]     fill_o,
    output logic                       udf_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    typedef struct packed {
        logic [DEPTH-1:0] mem;
        logic [PW-1:0]    wbin;
        logic [PW-1:0]    wgray;
        logic [PW-1:0]    rg_s1;
        logic [PW-1:0]    rg_s2;
        logic             ovf;
    } wr_st_t;

    typedef struct packed {
        logic [PW-1:0]    rbin;
        logic [PW-1:0]    rgray;
        logic [PW-1:0]    wg_s1;
        logic [PW-1:0]    wg_s2;
        logic             udf;
    } rd_st_t;

    wr_st_t wr_d, wr_q;
    rd_st_t rd_d, rd_q;
    logic [PW-1:0] wr_used;
    logic [PW-1:0] rd_fill;

    // write domain: capture one bit per rising edge unless full
    always_comb begin
        wr_d       = wr_q;
        wr_d.rg_s1 = rd_q.rgray;
        wr_d.rg_s2 = wr_q.rg_s1;
        wr_used    = wr_q.wbin - from_gray(wr_q.rg_s2);
        if (wr_used == PW'(DEPTH)) begin
            wr_d.ovf = 1'b1;
        end else begin
            wr_d.mem[wr_q.wbin[AW-1:0]] = wr_bit;
            wr_d.wbin  = wr_q.wbin + 1'b1;
            wr_d.wgray = to_gray(wr_q.wbin + 1'b1);
        end
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) wr_q <= '0;
        else        wr_q <= wr_d;
    end

    // read domain: fill seen through the synchronised write pointer
    always_comb begin
        rd_d       = rd_q;
        rd_d.wg_s1 = wr_q.wgray;
        rd_d.wg_s2 = rd_q.wg_s1;
        rd_fill    = from_gray(rd_q.wg_s2) - rd_q.rbin;
        rd_bit     = (rd_fill != '0) ? wr_q.mem[rd_q.rbin[AW-1:0]] : 1'b0;
        if (rd_en) begin
            if (rd_fill == '0) begin
                rd_d.udf = 1'b1;
            end else begin
                rd_d.rbin  = rd_q.rbin + 1'b1;
                rd_d.rgray = to_gray(rd_q.rbin + 1'b1);
            end
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign fill_o = rd_fill;
    assign udf_o  = rd_q.udf;
    assign ovf_o  = wr_q.ovf;
endmodule

// File: rtl/ds2_frame_seq.sv
`timescale 1ns/1ps
module ds2_frame_seq
    import ds2_mux_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  advance,
    output slot_t slot
);
    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic [BLK_W-1:0] blk;
        logic [BIT_W-1:0] bitc;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [BIT_W-1:0] pidx;

    always_comb begin
        cnt_d = cnt_q;
        if (advance) begin
            if (cnt_q.bitc == BIT_W'(BLK_LEN - 1)) begin
                cnt_d.bitc = '0;
                if (cnt_q.blk == BLK_W'(BLK_PER_SUB - 1)) begin
                    cnt_d.blk = '0;
                    if (cnt_q.sub == SUB_W'(NUM_SUB - 1)) cnt_d.sub = '0;
                    else                                  cnt_d.sub = cnt_q.sub + 1'b1;
                end else begin
                    cnt_d.blk = cnt_q.blk + 1'b1;
                end
            end else begin
                cnt_d.bitc = cnt_q.bitc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // decode the current position into a slot descriptor
    always_comb begin
        pidx             = cnt_q.bitc - 1'b1;
        slot.sub         = cnt_q.sub;
        slot.trib        = pidx[TRIB_W-1:0];
        slot.sub_first   = (cnt_q.blk == '0) && (cnt_q.bitc == '0);
        slot.frame_first = slot.sub_first && (cnt_q.sub == '0);
        if (cnt_q.bitc == '0) begin
            if (cnt_q.blk == '0)                             slot.kind = SLOT_MBIT;
            else if (cnt_q.blk == BLK_W'(2))                 slot.kind = SLOT_FZERO;
            else if (cnt_q.blk == BLK_W'(BLK_PER_SUB - 1))   slot.kind = SLOT_FONE;
            else                                             slot.kind = SLOT_CBIT;
        end else if ((cnt_q.blk == BLK_W'(STUFF_BLK)) && (pidx < BIT_W'(NUM_TRIB))
                     && (pidx[TRIB_W-1:0] == TRIB_W'(cnt_q.sub))) begin
            slot.kind = SLOT_STUFF;
        end else begin
            slot.kind = SLOT_DATA;
        end
    end
endmodule

// File: rtl/ds2_stuff_mux.sv
`timescale 1ns/1ps
module ds2_stuff_mux
    import ds2_mux_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TRIB-1:0] trib_clk,
    input  logic [NUM_TRIB-1:0] trib_data,
    input  logic                x_bit,
    output logic                ds2_data,
    output logic                ds2_frame_start,
    output logic [NUM_TRIB-1:0] fifo_udf,
    output logic [NUM_TRIB-1:0] fifo_ovf
);
    localparam int FILL_W = $clog2(FIFO_DEPTH) + 1;
    localparam int HALF   = FIFO_DEPTH / 2;

    typedef struct packed {
        logic                run;
        logic [NUM_TRIB-1:0] stuff;
        logic                dout;
        logic                fs;
    } mux_st_t;

    mux_st_t             st_d, st_q;
    slot_t               slot;
    logic [NUM_TRIB-1:0] rd_en;
    logic [NUM_TRIB-1:0] rd_bit;
    logic [FILL_W-1:0]   fill [NUM_TRIB];
    logic                tx_bit;
    logic                all_half;

    for (genvar i = 0; i < NUM_TRIB; i++) begin : g_fifo
        ds2_trib_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
            .rst_n  (rst_n),
            .wr_clk (trib_clk[i]),
            .wr_bit (trib_data[i]),
            .ovf_o  (fifo_ovf[i]),
            .rd_clk (clk),
            .rd_en  (rd_en[i]),
            .rd_bit (rd_bit[i]),
            .fill_o (fill[i]),
            .udf_o  (fifo_udf[i])
        );
    end

    ds2_frame_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (st_q.run),
        .slot    (slot)
    );

    always_comb begin
        st_d     = st_q;
        rd_en    = '0;
        tx_bit   = 1'b0;
        all_half = 1'b1;
        for (int i = 0; i < NUM_TRIB; i++) begin
            if (fill[i] < FILL_W'(HALF)) all_half = 1'b0;
        end
        st_d.run = st_q.run | all_half;
        if (st_q.run) begin
            unique case (slot.kind)
                SLOT_MBIT: begin
                    if (slot.sub == '0)                      tx_bit = 1'b0;
                    else if (slot.sub == SUB_W'(NUM_SUB - 1)) tx_bit = x_bit;
                    else                                     tx_bit = 1'b1;
                end
                SLOT_FZERO: tx_bit = 1'b0;
                SLOT_FONE:  tx_bit = 1'b1;
                SLOT_CBIT:  tx_bit = st_q.stuff[slot.sub];
                SLOT_DATA: begin
                    rd_en[slot.trib] = 1'b1;
                    tx_bit           = rd_bit[slot.trib];
                end
                SLOT_STUFF: begin
                    if (!st_q.stuff[slot.trib]) begin
                        rd_en[slot.trib] = 1'b1;
                        tx_bit           = rd_bit[slot.trib];
                    end
                end
                default: tx_bit = 1'b0;
            endcase
            if (slot.sub_first) begin
                st_d.stuff[slot.sub] = (fill[slot.sub] < FILL_W'(HALF));
            end
        end
        st_d.dout = tx_bit;
        st_d.fs   = st_q.run && slot.frame_first;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ds2_data        = st_q.dout;
    assign ds2_frame_start = st_q.fs;
endmodule

// File: rtl/ds2_stuff_mux_chk.sv
`timescale 1ns/1ps
module ds2_stuff_mux_chk
    import ds2_mux_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                x_bit,
    input logic                ds2_data,
    input logic                ds2_frame_start,
    input logic [NUM_TRIB-1:0] fifo_udf
);
    localparam int CW = $clog2(FRAME_LEN + 1);

    logic          seen_q;
    logic          cref_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cur_pos;
    logic [CW-1:0] sub_off;

    always_comb begin
        cur_pos = ds2_frame_start ? '0 : cnt_q;
        sub_off = cur_pos % CW'(SUB_LEN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            cref_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (ds2_frame_start) seen_q <= 1'b1;
            cnt_q <= ds2_frame_start ? CW'(1) : cnt_q + 1'b1;
            if (sub_off == CW'(BLK_LEN)) cref_q <= ds2_data;
        end
    end

    AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (ds2_frame_start == (cnt_q == CW'(FRAME_LEN)))); // R1
    AST_FIRST_MBIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ds2_frame_start |-> !ds2_data); // R3
    AST_XBIT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && cur_pos == CW'(3 * SUB_LEN)) |-> (ds2_data == $past(x_bit))); // R4
    AST_CBITS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && (sub_off == CW'(3 * BLK_LEN) || sub_off == CW'(4 * BLK_LEN)))
        |-> (ds2_data == cref_q)); // R5
    AST_QUIET_START: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !ds2_data); // R9
    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_udf != '0) |=> ((fifo_udf & $past(fifo_udf)) == $past(fifo_udf))); // R10
endmodule

bind ds2_stuff_mux ds2_stuff_mux_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .x_bit           (x_bit),
    .ds2_data        (ds2_data),
    .ds2_frame_start (ds2_frame_start),
    .fifo_udf        (fifo_udf)
);

// File: tb/ds2_stuff_mux_bench.sv
`timescale 1ns/1ps
module ds2_stuff_mux_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tclk;
    logic [3:0] tdata;
    logic       x_bit = 1'b0;
    logic       ds2_data;
    logic       ds2_frame_start;
    logic [3:0] fifo_udf;
    logic [3:0] fifo_ovf;

    real        hp [4] = '{16.34, 16.36, 16.38, 16.35};
    logic [3:0] tclk_en = 4'hf;
    bit         chk_en [4] = '{1, 1, 1, 1};
    bit         cval [4] = '{0, 0, 0, 0};
    int         stuff_cnt [4] = '{0, 0, 0, 0};
    int         nostuff_cnt [4] = '{0, 0, 0, 0};
    int         pos = -1;
    int         checks = 0;
    int         errors = 0;

    typedef bit bitq_t[$];
    bitq_t exp_q [4];

    always #4 clk = ~clk;

    ds2_stuff_mux u_ds2_stuff_mux (
        .clk             (clk),
        .rst_n           (rst_n),
        .trib_clk        (tclk),
        .trib_data       (tdata),
        .x_bit           (x_bit),
        .ds2_data        (ds2_data),
        .ds2_frame_start (ds2_frame_start),
        .fifo_udf        (fifo_udf),
        .fifo_ovf        (fifo_ovf)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (pos %0d)", tag, act, exp, pos);
        end
    endtask

    task automatic push_exp(int ch, bit b);
        exp_q[ch].push_back(b);
    endtask

    // tributary drivers: new data on falling edges, expected bits recorded on capture edges
    for (genvar g = 0; g < 4; g++) begin : g_trib
        logic c = 1'b0;
        logic d = 1'b0;
        assign tclk[g]  = c;
        assign tdata[g] = d;
        initial forever begin
            #(hp[g]);
            if (tclk_en[g]) c = ~c;
        end
        always @(negedge c) d <= 1'($urandom_range(0, 1));
        always @(posedge c) if (rst_n) push_exp(g, d);
    end

    task automatic check_slot();
        int sub, r, blk, b, k, ch;
        bit e;
        sub = pos / 294;
        r   = pos % 294;
        blk = r / 49;
        b   = r % 49;
        if (b == 0) begin
            if (blk == 0) begin
                if (sub == 3) chk("R4 x-bit slot", ds2_data, x_bit);
                else          chk("R3 M bit", ds2_data, (sub == 0) ? 0 : 1);
            end else if (blk == 2) begin
                chk("R3 F0 bit", ds2_data, 0);
            end else if (blk == 5) begin
                chk("R3 F1 bit", ds2_data, 1);
            end else if (blk == 1) begin
                cval[sub] = ds2_data;
            end else begin
                chk("R5 C bits identical", ds2_data, cval[sub]);
            end
        end else begin
            k  = b - 1;
            ch = k % 4;
            if (blk == 5 && k == sub && cval[ch]) begin
                stuff_cnt[ch]++;
                chk($sformatf("R6 stuffed slot ch%0d carries 0", ch), ds2_data, 0);
            end else begin
                if (blk == 5 && k == sub) nostuff_cnt[ch]++;
                if (chk_en[ch]) begin
                    // R2 interleave and R8 order are both checked by this pop
                    if (exp_q[ch].size() == 0) begin
                        chk($sformatf("R8 data available ch%0d", ch), 0, 1);
                    end else begin
                        e = exp_q[ch].pop_front();
                        chk($sformatf("R8 data order ch%0d", ch), ds2_data, e);
                    end
                end
            end
        end
    endtask

    // monitor: samples on falling clock edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (pos < 0) begin
                if (ds2_frame_start) pos = 0;
                else chk("R9 quiet before first frame", ds2_data, 0);
            end else begin
                pos = (pos + 1) % 1176;
                chk("R1 frame strobe", ds2_frame_start, (pos == 0) ? 1 : 0);
            end
            if (pos >= 0) check_slot();
        end
    end

    task automatic wait_frames(int n);
        repeat (n) @(posedge ds2_frame_start);
        #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk("R12 reset data", ds2_data, 0);
        chk("R12 reset strobe", ds2_frame_start, 0);
        chk("R12 reset udf", fifo_udf, 0);
        chk("R12 reset ovf", fifo_ovf, 0);
        rst_n = 1'b1;
        wait_frames(1);
        wait_frames(5);
        x_bit = 1'b1;
        wait_frames(4);
        x_bit = 1'b0;
        wait_frames(4);
        chk("R10 no underflow at nominal rates", fifo_udf, 0);
        chk("R11 no overflow at nominal rates", fifo_ovf, 0);
        chk("R7 slow ch2 stuffs more than fast ch0", (stuff_cnt[2] > stuff_cnt[0]) ? 1 : 0, 1);
        chk("R7 mid-rate ch1 both stuffs", (stuff_cnt[1] > 0) ? 1 : 0, 1);
        chk("R7 mid-rate ch1 both data", (nostuff_cnt[1] > 0) ? 1 : 0, 1);
        // stop tributary 3, race tributary 2
        chk_en[3]  = 0;
        chk_en[2]  = 0;
        tclk_en[3] = 1'b0;
        hp[2]      = 5.0;
        wait_frames(3);
        chk("R10 udf set on starved ch3", fifo_udf, 4'b1000);
        chk("R11 ovf set on raced ch2", fifo_ovf, 4'b0100);
        chk("R7 empty ch3 signals stuff", cval[3], 1);
        chk("R7 full ch2 signals no stuff", cval[2], 0);
        wait_frames(1);
        chk("R10 udf still held", fifo_udf[3], 1);
        chk("R11 ovf still held", fifo_ovf[2], 1);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule